// File: doc/BRIEF.md
# Video Pixel Grab Strobe Generator

This block marks one chosen sample position in a digitised video stream with a single-clock grab strobe, so that a downstream capture stage can latch the decoded value found there. It runs on the pixel clock and counts three things: samples since the last horizontal sync edge, lines since the last field start, and fields in a repeating sequence whose length is programmable (four fields for 525-line systems, eight for 625-line systems). Each count is compared with a programmed target. The three hit flags are exported as a status word and combined into the strobe according to the mode inputs.

The sample position uses a quadrant code rather than a plain count. The line of STS samples is split into four quadrants of Int(STS/4) samples each. The code puts the quadrant in bits [10:9] and a 9-bit offset below it. The offset runs from 512 - Int(STS/4) up to 511 within each quadrant. The zero to three samples left over after the fourth quadrant are coded as 1536 plus their excess. The upstream data path lags the counter by 28 samples. A target that codes position n therefore picks the data sample n - 28, so position 28 picks the first active sample after sync. An external trigger mode replaces the counters with a falling edge on an asynchronous input pin.

Top module: `pixel_grab_gen`

## Requirements
- R1: After each sync edge, position n is coded as (n / Q) * 512 + (512 - Q + n mod Q) for n < 4Q, and as 1536 + (n - 4Q) above that, where Q = Int(STS/4). STS is sampled at the sync edge and held for the whole line.
- R2: A sync edge is a clock edge that samples hsync_i high after sampling it low. Call that edge E0. If the target equals the code of position n, status bit 0 is high exactly in the clock cycle that follows edge E0 + n + 1.
- R3: The line count clears on a sampled field_start_i pulse, which wins over a sync edge at the same clock edge. Otherwise it increments on each sync edge. Status bit 1 is high, one cycle later, for every cycle in which the line count equals the line target.
- R4: The field count advances on each field_start_i pulse and wraps to 0 after reaching field_last_i. Status bit 2 is high, one cycle later, while the field count equals the field target.
- R5: With ext_mode_i low, grab_en_i high and gate_all_i high, grab_o equals the AND of the three status bits, in the same cycle.
- R6: With ext_mode_i low, grab_en_i high and gate_all_i low, the line and field hits are ignored and grab_o equals status bit 0.
- R7: With ext_mode_i low and grab_en_i low, grab_o stays 0 whatever the counters do.
- R8: With ext_mode_i high, ext_trig_i passes through a two-flop synchroniser. Let edge k be the first edge that samples the pin low after an edge that sampled it high. grab_o is then high for exactly the one cycle after edge k + 2. The enable and gating inputs have no effect in this mode.
- R9: While rst is high, grab_o and the status word are 0. Reset leaves the counters at position 0 (coded from the current STS), line 0 and field 0, with the trigger synchroniser idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync level; its rising edge restarts the sample count |
| field_start_i | input | 1 | One-cycle pulse at the start of each field |
| sts_i | input | STS_W | Total samples per line |
| pix_target_i | input | 11 | Quadrant-coded sample target |
| line_target_i | input | LINE_W | Line target within the field |
| field_target_i | input | FIELD_W | Field target within the sequence |
| field_last_i | input | FIELD_W | Highest field number before wrap (3 or 7 typical) |
| gate_all_i | input | 1 | 1: require line and field hits as well; 0: sample hit alone |
| grab_en_i | input | 1 | Enables the counter-driven strobe |
| ext_mode_i | input | 1 | Selects the external trigger as strobe source |
| ext_trig_i | input | 1 | Asynchronous external trigger, active on falling edge |
| grab_o | output | 1 | Registered one-cycle grab strobe |
| match_status_o | output | 3 | Registered hits: bit 0 sample, bit 1 line, bit 2 field |

## Verification
Some properties hold on every cycle, and the assertions check these. They check the quadrant step of the sample code and the clearing of the code on sync. They check line clear and hold, field wrap, and that the external-mode strobe never lasts two cycles. They also check how grab_o relates to the status word in each of the three counter modes, and that outputs are quiet after reset. Some facts only show up over many cycles, and only the bench scenarios can show them. These are the exact coded value at each position, including the leftover samples and extreme STS values. They also cover the latency from a sync edge or a trigger edge to the strobe, the number of fields between grabs in gated mode, and STS being latched per line.

// File: rtl/pgrab_pkg.sv
package pgrab_pkg;
  localparam int OFF_W  = 9;
  localparam int QUAD_W = 2;
  localparam int CODE_W = OFF_W + QUAD_W;

  typedef logic [CODE_W-1:0] pix_code_t;

  typedef struct packed {
    logic field_hit;
    logic line_hit;
    logic pix_hit;
  } hit_t;

  typedef enum logic [1:0] {
    SRC_OFF,
    SRC_PIXEL,
    SRC_ALL,
    SRC_EXT
  } grab_src_e;
endpackage

// File: rtl/pg_pix_count.sv
module pg_pix_count import pgrab_pkg::*; #(
  parameter int STS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_i,
  input  logic [STS_W-1:0] sts_i,
  output pix_code_t        code_o,
  output logic             sol_o
);
  logic              hs_d;
  logic              hs_rise;
  logic [STS_W-1:0]  sts_q;
  logic [QUAD_W-1:0] quad_q;
  logic [OFF_W-1:0]  off_q;

  // First offset of a quadrant: 512 minus the quadrant size.
  function automatic logic [OFF_W-1:0] first_off(input logic [STS_W-1:0] s);
    logic [STS_W-1:0] d;
    d = STS_W'(512) - (s >> 2);
    return d[OFF_W-1:0];
  endfunction

  assign hs_rise = hsync_i & ~hs_d;

  always_ff @(posedge clk) begin
    if (rst) hs_d <= 1'b0;
    else     hs_d <= hsync_i;
  end

  always_ff @(posedge clk) begin
    if (rst || hs_rise) begin
      sts_q  <= sts_i;
      quad_q <= '0;
      off_q  <= first_off(sts_i);
    end else if (off_q == '1 && quad_q != '1) begin
      quad_q <= quad_q + 2'd1;
      off_q  <= first_off(sts_q);
    end else begin
      off_q  <= off_q + 9'd1;
    end
  end

  assign code_o = {quad_q, off_q};
  assign sol_o  = hs_rise;

  AST_QUAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (!hs_rise && off_q == '1 && quad_q != '1) |=> (quad_q == $past(quad_q) + 2'd1 && off_q == first_off(sts_q))); // R1
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
    hs_rise |=> (quad_q == '0 && sts_q == $past(sts_i))); // R1
endmodule

// File: rtl/pg_line_field.sv
module pg_line_field #(
  parameter int LINE_W  = 10,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sol_i,
  input  logic               field_start_i,
  input  logic [FIELD_W-1:0] field_last_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [FIELD_W-1:0] field_o
);
  logic [LINE_W-1:0]  line_q;
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (rst || field_start_i) line_q <= '0;
    else if (sol_i)           line_q <= line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) field_q <= '0;
    else if (field_start_i)
      field_q <= (field_q == field_last_i) ? '0 : field_q + 1'b1;
  end

  assign line_o  = line_q;
  assign field_o = field_q;

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    field_start_i |=> (line_q == '0)); // R3
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!field_start_i && !sol_i) |=> $stable(line_q)); // R3
  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (field_start_i && field_q == field_last_i) |=> (field_q == '0)); // R4
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !field_start_i |=> $stable(field_q)); // R4
endmodule

// File: rtl/pg_ext_trig.sv
module pg_ext_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic fall_o
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[DEPTH-2:0], trig_i};
  end

  // Oldest stage still high, newest synchronised stage low.
  assign fall_o = sh_q[DEPTH-1] & ~sh_q[DEPTH-2];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o); // R8
endmodule

// File: rtl/pixel_grab_gen.sv
module pixel_grab_gen import pgrab_pkg::*; #(
  parameter int STS_W   = 12,
  parameter int LINE_W  = 10,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsync_i,
  input  logic               field_start_i,
  input  logic [STS_W-1:0]   sts_i,
  input  logic [CODE_W-1:0]  pix_target_i,
  input  logic [LINE_W-1:0]  line_target_i,
  input  logic [FIELD_W-1:0] field_target_i,
  input  logic [FIELD_W-1:0] field_last_i,
  input  logic               gate_all_i,
  input  logic               grab_en_i,
  input  logic               ext_mode_i,
  input  logic               ext_trig_i,
  output logic               grab_o,
  output logic [2:0]         match_status_o
);
  pix_code_t          code;
  logic               sol;
  logic [LINE_W-1:0]  line_cnt;
  logic [FIELD_W-1:0] field_cnt;
  logic               ext_fall;
  hit_t               hit;
  grab_src_e          src;
  logic               grab_next;
  logic               grab_q;
  hit_t               status_q;

  pg_pix_count #(.STS_W(STS_W)) u_pix (
    .clk     (clk),
    .rst     (rst),
    .hsync_i (hsync_i),
    .sts_i   (sts_i),
    .code_o  (code),
    .sol_o   (sol)
  );

  pg_line_field #(.LINE_W(LINE_W), .FIELD_W(FIELD_W)) u_lf (
    .clk           (clk),
    .rst           (rst),
    .sol_i         (sol),
    .field_start_i (field_start_i),
    .field_last_i  (field_last_i),
    .line_o        (line_cnt),
    .field_o       (field_cnt)
  );

  pg_ext_trig #(.SYNC_STAGES(2)) u_ext (
    .clk    (clk),
    .rst    (rst),
    .trig_i (ext_trig_i),
    .fall_o (ext_fall)
  );

  always_comb begin
    hit.pix_hit   = (code == pix_target_i);
    hit.line_hit  = (line_cnt == line_target_i);
    hit.field_hit = (field_cnt == field_target_i);
  end

  always_comb begin
    if (ext_mode_i)      src = SRC_EXT;
    else if (!grab_en_i) src = SRC_OFF;
    else if (gate_all_i) src = SRC_ALL;
    else                 src = SRC_PIXEL;
  end

  always_comb begin
    unique case (src)
      SRC_EXT:   grab_next = ext_fall;
      SRC_ALL:   grab_next = hit.pix_hit & hit.line_hit & hit.field_hit;
      SRC_PIXEL: grab_next = hit.pix_hit;
      default:   grab_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grab_q   <= 1'b0;
      status_q <= '0;
    end else begin
      grab_q   <= grab_next;
      status_q <= hit;
    end
  end

  assign grab_o         = grab_q;
  assign match_status_o = status_q;

  AST_ALL_GATE: assert property (@(posedge clk) disable iff (rst)
    (gate_all_i && grab_en_i && !ext_mode_i) |=> (grab_o == (&match_status_o))); // R5
  AST_PIX_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!gate_all_i && grab_en_i && !ext_mode_i) |=> (grab_o == match_status_o[0])); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!grab_en_i && !ext_mode_i) |=> !grab_o); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!grab_o && match_status_o == 3'b000)); // R9
endmodule

// File: tb/pixel_grab_gen_tb.sv
`timescale 1ns/1ps
module pixel_grab_gen_tb;
  localparam int STS_W   = 12;
  localparam int LINE_W  = 10;
  localparam int FIELD_W = 3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               hsync = 1'b0;
  logic               fstart = 1'b0;
  logic [STS_W-1:0]   sts = 12'd23;
  logic [10:0]        pix_tgt = 11'd0;
  logic [LINE_W-1:0]  line_tgt = '0;
  logic [FIELD_W-1:0] field_tgt = '0;
  logic [FIELD_W-1:0] field_last = 3'd3;
  logic               gate = 1'b0;
  logic               en = 1'b1;
  logic               ext = 1'b0;
  logic               trig = 1'b1;
  logic               grab;
  logic [2:0]         status;

  always #2.5 clk = ~clk;

  pixel_grab_gen u_dut (
    .clk(clk), .rst(rst), .hsync_i(hsync), .field_start_i(fstart), .sts_i(sts),
    .pix_target_i(pix_tgt), .line_target_i(line_tgt), .field_target_i(field_tgt),
    .field_last_i(field_last), .gate_all_i(gate), .grab_en_i(en), .ext_mode_i(ext),
    .ext_trig_i(trig), .grab_o(grab), .match_status_o(status)
  );

  typedef struct {
    int       cyc;
    logic     grab;
    logic [2:0] st;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // model state
  int m_raw = 0, m_line = 0, m_field = 0, m_sts = 23;
  bit m_hsd = 0;
  bit h1 = 1, h2 = 1, h3 = 1;
  int linepos = 0, linecnt = 0, lpf = 3;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int enc(int raw, int s);
    int qs;
    qs = s / 4;
    if (raw < 4 * qs) return ((raw / qs) << 9) | (512 - qs + raw % qs);
    return 1536 + raw - 4 * qs;
  endfunction

  // Driver: drive inputs for the next edge, push expected outputs.
  task automatic step(bit tr, string tag);
    exp_t e;
    bit hs, fs, pm, lm, fm, rise;
    hs = (linepos == 0);
    fs = hs && (linecnt % lpf == 0);
    hsync = hs; fstart = fs; trig = tr;
    pm = (int'(pix_tgt) == enc(m_raw, m_sts));
    lm = (int'(line_tgt) == m_line);
    fm = (int'(field_tgt) == m_field);
    e.cyc = cyc + 1;
    e.st  = {fm, lm, pm};
    if (ext)       e.grab = (!h2 && h3);
    else if (!en)  e.grab = 1'b0;
    else if (gate) e.grab = pm & lm & fm;
    else           e.grab = pm;
    e.tag = tag;
    q.push_back(e);
    rise = hs && !m_hsd;
    m_hsd = hs;
    if (rise) begin m_raw = 0; m_sts = int'(sts); end
    else m_raw++;
    if (fs) m_line = 0;
    else if (rise) m_line++;
    if (fs) m_field = (m_field == int'(field_last)) ? 0 : m_field + 1;
    h3 = h2; h2 = h1; h1 = tr;
    linepos++;
    if (linepos >= int'(sts)) begin linepos = 0; linecnt++; end
    @(negedge clk);
  endtask

  task automatic run_lines(int n, string tag);
    for (int i = 0; i < n * int'(sts); i++) step(1'b1, tag);
  endtask

  task automatic to_line_start(string tag);
    while (linepos != 0) step(1'b1, tag);
  endtask

  // Monitor: compare outputs against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (grab !== e.grab) begin
          errors++;
          $display("FAIL %s cycle %0d grab actual %b expected %b", e.tag, cyc, grab, e.grab);
        end
        checks++;
        if (status !== e.st) begin
          errors++;
          $display("FAIL %s cycle %0d status actual %b expected %b", e.tag, cyc, status, e.st);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pix_tgt = 11'(enc(0, 23));
    repeat (3) @(negedge clk);
    checks++;
    if (grab !== 1'b0 || status !== 3'b000) begin
      errors++;
      $display("FAIL R9 reset outputs actual %b/%b expected 0/000", grab, status);
    end
    rst = 1'b0;
    // position 0 right after reset and after first sync (R9, R2)
    run_lines(2, "R9_R2");

    // pixel-only mode, mid quadrant target (R6, R2, R1)
    pix_tgt = 11'(enc(7, 23));
    run_lines(4, "R6_pixel_only");
    // excess samples after the fourth quadrant (R1)
    pix_tgt = 11'(enc(21, 23));
    run_lines(3, "R1_excess");
    pix_tgt = 11'(enc(19, 23));
    run_lines(2, "R1_quad3_end");

    // full gating over a whole field sequence (R5, R3, R4)
    gate = 1'b1; pix_tgt = 11'(enc(10, 23)); line_tgt = 1; field_tgt = 2;
    run_lines(15, "R5_R3_R4");
    // shorter field sequence (R4 wrap)
    field_last = 3'd1; field_tgt = 1; line_tgt = 2;
    run_lines(12, "R4_wrap");

    // disabled (R7)
    en = 1'b0; gate = 1'b0; pix_tgt = 11'(enc(3, 23));
    run_lines(3, "R7_disabled");

    // external trigger, enable settings ignored (R8)
    ext = 1'b1; en = 1'b1; gate = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, "R8_idle");
    for (int i = 0; i < 4; i++) step(1'b0, "R8_fall");
    for (int i = 0; i < 3; i++) step(1'b1, "R8_rise");
    step(1'b0, "R8_short_low");
    for (int i = 0; i < 6; i++) step(1'b1, "R8_after");
    en = 1'b0;
    step(1'b0, "R8_en_off");
    for (int i = 0; i < 6; i++) step(1'b1, "R8_en_off");
    ext = 1'b0; en = 1'b1; gate = 1'b0;
    to_line_start("R6_resume");

    // largest quadrants, start offset 0 (R1)
    sts = 12'd2051; pix_tgt = 11'(enc(2049, 2051));
    run_lines(2, "R1_sts2051");
    pix_tgt = 11'(enc(1030, 2051));
    run_lines(1, "R1_sts2051_mid");
    // no excess samples (R1)
    sts = 12'd8; pix_tgt = 11'(enc(5, 8));
    run_lines(4, "R1_sts8");

    for (int i = 0; i < 3; i++) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule